// File: doc/BRIEF.md
# Capability Access Permission Checker

This block decides whether one memory access may proceed under a capability. Each cycle in which the valid strobe is high, it takes a capability descriptor (tag, sealed flag, permission mask, base and a top one bit wider than an address) together with the requested permission mask, the access address and length, and the index of the capability register the access names. It then judges the access against four rules: tag, seal, permission and bounds. When several rules fail, only the one with the highest priority is reported.

One cycle after the strobe, the result appears on registered outputs: a result-valid pulse, a fault flag and an encoded cause. On a faulting access the address is captured as the bad virtual address and the register index is captured with it. The outputs hold their values until the next strobe. The trap logic around the block reads the outputs in the cycle of the pulse.

The bounds rule measures the access end as address plus length. It carries the sum one bit wider than an address, so an access that runs past the top of the address space is caught and is never folded back to a low address.

Top module: `capchk_top`

## Requirements
- R1: A descriptor with its tag clear yields cause 1 (tag), whatever the seal, permission and bounds inputs are.
- R2: A descriptor with its tag set and its sealed flag set yields cause 2 (seal), whatever the permission and bounds inputs are.
- R3: With tag set and unsealed, a request equal to exactly one of the single-bit masks at bit EXEC_BIT (1), LOAD_BIT (2) or STORE_BIT (3), where that bit is absent from the capability mask, yields cause 3 (execute), 4 (load) or 5 (store) respectively.
- R4: A request mask that is not exactly one of those three single-bit masks never yields a permission cause, even when some of its bits are absent from the capability mask.
- R5: With the rules above satisfied, an address below the base yields cause 6 (bounds). An address equal to the base is accepted.
- R6: An access whose address plus length reaches 2^ADDR_W or more yields cause 6, even when the top is wider still.
- R7: An access end (address plus length) strictly above the top yields cause 6. An end equal to the top is accepted.
- R8: The priority is tag, then seal, then permission, then bounds. A passing access reports cause 0 with the fault flag low.
- R9: The result-valid output is high exactly in the cycle after each strobe. The cause and fault flag change only in that cycle and hold otherwise.
- R10: On a faulting access, the bad-address output takes the access address and the register output takes the register index. A passing access leaves both unchanged.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chkValid | input | 1 | Access present this cycle |
| capTag | input | 1 | Capability tag |
| capSealed | input | 1 | Capability is sealed |
| capPerms | input | PERM_W | Capability permission mask |
| capBase | input | ADDR_W | Lowest address allowed |
| capTop | input | ADDR_W+1 | One past the highest address allowed |
| reqPerms | input | PERM_W | Permission mask requested by the access |
| accAddr | input | ADDR_W | Access address |
| accLen | input | LEN_W | Access length in bytes |
| capRegNum | input | REG_W | Index of the authorising capability register |
| resValid | output | 1 | Result present (one cycle after the strobe) |
| resFault | output | 1 | Access refused |
| resCause | output | 3 | Cause: 0 none, 1 tag, 2 seal, 3 exec, 4 load, 5 store, 6 bounds |
| resRegNum | output | REG_W | Register index of the last fault |
| badAddr | output | ADDR_W | Address of the last fault |

## Verification
The first stimulus is a set of stacked failures. Each access fails several rules at once, and one rule is removed at a time, which shows whether each level of the priority masks the levels below it. The bounds rule is tried at the base and one byte below it, at the top and one byte above it, and at the carry edge: an access ending exactly at 2^64 under a top of 2^64 and under a top of 2^65-1, which tells the carry test apart from the top comparison. Request masks with two bits set show that only single-kind requests can raise a permission cause. A long run of random descriptors, with base, top and address drawn close together, is compared cycle by cycle against a behavioural priority model, together with the hold behaviour of the bad address between faults.

// File: rtl/capchk_pkg.sv
package capchk_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_TAG        = 3'd1,
    CAUSE_SEAL       = 3'd2,
    CAUSE_PERM_EXEC  = 3'd3,
    CAUSE_PERM_LOAD  = 3'd4,
    CAUSE_PERM_STORE = 3'd5,
    CAUSE_BOUNDS     = 3'd6
  } faultCause_e;

  typedef enum logic [1:0] {
    KIND_OTHER,
    KIND_EXEC,
    KIND_LOAD,
    KIND_STORE
  } reqKind_e;

  // Raw rule outcomes computed by the datapath
  typedef struct packed {
    logic     tagClear;
    logic     sealed;
    logic     permMissing;
    reqKind_e kind;
    logic     belowBase;
    logic     endCarry;
    logic     aboveTop;
  } checkFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic        loadResult;
    logic        loadFaultInfo;
    faultCause_e cause;
  } ctlStrobes_t;

endpackage

// File: rtl/capchk_datapath.sv
module capchk_datapath
  import capchk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 16,
  parameter int PERM_W    = 12,
  parameter int REG_W     = 5,
  parameter int EXEC_BIT  = 1,
  parameter int LOAD_BIT  = 2,
  parameter int STORE_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capTag,
  input  logic              capSealed,
  input  logic [PERM_W-1:0] capPerms,
  input  logic [ADDR_W-1:0] capBase,
  input  logic [ADDR_W:0]   capTop,
  input  logic [PERM_W-1:0] reqPerms,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LEN_W-1:0]  accLen,
  input  logic [REG_W-1:0]  capRegNum,
  input  ctlStrobes_t       strobes,
  output checkFlags_t       flags,
  output logic              resFault,
  output logic [2:0]        resCause,
  output logic [REG_W-1:0]  resRegNum,
  output logic [ADDR_W-1:0] badAddr
);

  localparam int SUM_W = ADDR_W + 1;
  localparam int PAD_W = SUM_W - LEN_W;
  localparam logic [PERM_W-1:0] ONE_MASK   = {{(PERM_W-1){1'b0}}, 1'b1};
  localparam logic [PERM_W-1:0] EXEC_MASK  = ONE_MASK << EXEC_BIT;
  localparam logic [PERM_W-1:0] LOAD_MASK  = ONE_MASK << LOAD_BIT;
  localparam logic [PERM_W-1:0] STORE_MASK = ONE_MASK << STORE_BIT;

  // Per-bit missing permission detection
  logic [PERM_W-1:0] bitMissing;
  for (genvar i = 0; i < PERM_W; i++) begin : g_permBit
    assign bitMissing[i] = reqPerms[i] & ~capPerms[i];
  end

  logic [SUM_W-1:0] endSum;
  assign endSum = {1'b0, accAddr} + {{PAD_W{1'b0}}, accLen};

  reqKind_e kindDec;
  always_comb begin
    if (reqPerms == EXEC_MASK)       kindDec = KIND_EXEC;
    else if (reqPerms == LOAD_MASK)  kindDec = KIND_LOAD;
    else if (reqPerms == STORE_MASK) kindDec = KIND_STORE;
    else                             kindDec = KIND_OTHER;
  end

  always_comb begin
    flags.tagClear    = ~capTag;
    flags.sealed      = capSealed;
    flags.permMissing = |bitMissing;
    flags.kind        = kindDec;
    flags.belowBase   = accAddr < capBase;
    flags.endCarry    = endSum[ADDR_W];
    flags.aboveTop    = endSum > capTop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resFault <= 1'b0;
      resCause <= '0;
    end else if (strobes.loadResult) begin
      resFault <= strobes.cause != CAUSE_NONE;
      resCause <= strobes.cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resRegNum <= '0;
      badAddr   <= '0;
    end else if (strobes.loadFaultInfo) begin
      resRegNum <= capRegNum;
      badAddr   <= accAddr;
    end
  end

  assert_bad_addr_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFaultInfo |=> (badAddr == $past(accAddr)) && (resRegNum == $past(capRegNum)));

  assert_fault_info_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadFaultInfo |=> $stable(badAddr) && $stable(resRegNum));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> $stable(resCause) && $stable(resFault));

endmodule

// File: rtl/capchk_control.sv
module capchk_control
  import capchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkValid,
  input  checkFlags_t flags,
  output ctlStrobes_t strobes,
  output logic        resValid
);

  faultCause_e causeSel;

  // Fixed priority: tag, seal, permission, bounds
  always_comb begin
    causeSel = CAUSE_NONE;
    if (flags.tagClear) begin
      causeSel = CAUSE_TAG;
    end else if (flags.sealed) begin
      causeSel = CAUSE_SEAL;
    end else if (flags.permMissing && flags.kind != KIND_OTHER) begin
      unique case (flags.kind)
        KIND_EXEC:  causeSel = CAUSE_PERM_EXEC;
        KIND_LOAD:  causeSel = CAUSE_PERM_LOAD;
        KIND_STORE: causeSel = CAUSE_PERM_STORE;
        default:    causeSel = CAUSE_NONE;
      endcase
    end else if (flags.belowBase || flags.endCarry || flags.aboveTop) begin
      causeSel = CAUSE_BOUNDS;
    end
  end

  always_comb begin
    strobes.loadResult    = chkValid;
    strobes.loadFaultInfo = chkValid && (causeSel != CAUSE_NONE);
    strobes.cause         = causeSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= chkValid;
  end

  assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> resValid);

  assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !resValid);

endmodule

// File: rtl/capchk_top.sv
module capchk_top
  import capchk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 16,
  parameter int PERM_W    = 12,
  parameter int REG_W     = 5,
  parameter int EXEC_BIT  = 1,
  parameter int LOAD_BIT  = 2,
  parameter int STORE_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic              capTag,
  input  logic              capSealed,
  input  logic [PERM_W-1:0] capPerms,
  input  logic [ADDR_W-1:0] capBase,
  input  logic [ADDR_W:0]   capTop,
  input  logic [PERM_W-1:0] reqPerms,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LEN_W-1:0]  accLen,
  input  logic [REG_W-1:0]  capRegNum,
  output logic              resValid,
  output logic              resFault,
  output logic [2:0]        resCause,
  output logic [REG_W-1:0]  resRegNum,
  output logic [ADDR_W-1:0] badAddr
);

  checkFlags_t flags;
  ctlStrobes_t strobes;

  capchk_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PERM_W(PERM_W), .REG_W(REG_W),
    .EXEC_BIT(EXEC_BIT), .LOAD_BIT(LOAD_BIT), .STORE_BIT(STORE_BIT)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .capTag(capTag), .capSealed(capSealed), .capPerms(capPerms),
    .capBase(capBase), .capTop(capTop), .reqPerms(reqPerms),
    .accAddr(accAddr), .accLen(accLen), .capRegNum(capRegNum),
    .strobes(strobes), .flags(flags),
    .resFault(resFault), .resCause(resCause),
    .resRegNum(resRegNum), .badAddr(badAddr)
  );

  capchk_control control_i (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .flags(flags), .strobes(strobes), .resValid(resValid)
  );

  localparam logic [ADDR_W:0] SPACE_END = {1'b0, {ADDR_W{1'b1}}};

  assert_tag_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && !capTag |=> resCause == CAUSE_TAG);

  assert_seal_second_R2: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && capTag && capSealed |=> resCause == CAUSE_SEAL);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && capTag && !capSealed && ((capPerms & reqPerms) == reqPerms) &&
    (({1'b0, accAddr} + (ADDR_W+1)'(accLen)) > SPACE_END) |=> resCause == CAUSE_BOUNDS);

  assert_fault_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resFault == (resCause != CAUSE_NONE));

endmodule

// File: tb/capchk_tb_top.sv
module capchk_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 16;
  localparam int PERM_W = 12;
  localparam int REG_W  = 5;
  localparam logic [PERM_W-1:0] MX = 12'h002;  // bit 1
  localparam logic [PERM_W-1:0] ML = 12'h004;  // bit 2
  localparam logic [PERM_W-1:0] MS = 12'h008;  // bit 3
  localparam logic [ADDR_W:0]   TOP_FULL = {1'b1, {ADDR_W{1'b0}}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chkValid = 1'b0;
  logic capTag = 1'b0, capSealed = 1'b0;
  logic [PERM_W-1:0] capPerms = '0, reqPerms = '0;
  logic [ADDR_W-1:0] capBase = '0, accAddr = '0;
  logic [ADDR_W:0]   capTop = '0;
  logic [LEN_W-1:0]  accLen = '0;
  logic [REG_W-1:0]  capRegNum = '0;
  logic resValid, resFault;
  logic [2:0] resCause;
  logic [REG_W-1:0] resRegNum;
  logic [ADDR_W-1:0] badAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [2:0] expCause = 0;
  logic [REG_W-1:0] expReg = 0;
  logic [ADDR_W-1:0] expBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capchk_top dut_i (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .capTag(capTag), .capSealed(capSealed), .capPerms(capPerms),
    .capBase(capBase), .capTop(capTop), .reqPerms(reqPerms),
    .accAddr(accAddr), .accLen(accLen), .capRegNum(capRegNum),
    .resValid(resValid), .resFault(resFault), .resCause(resCause),
    .resRegNum(resRegNum), .badAddr(badAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ADDR_W:0] act, input logic [ADDR_W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: returns the cause number
  function automatic int refCause(input bit tg, input bit sl, input logic [PERM_W-1:0] pm,
      input logic [ADDR_W-1:0] bs, input logic [ADDR_W:0] tp, input logic [PERM_W-1:0] rq,
      input logic [ADDR_W-1:0] ad, input logic [LEN_W-1:0] ln);
    logic [ADDR_W:0] room;
    logic [ADDR_W:0] lastEnd;
    if (!tg) return 1;
    if (sl) return 2;
    if ((pm & rq) != rq) begin
      if (rq == MX) return 3;
      if (rq == ML) return 4;
      if (rq == MS) return 5;
    end
    if (ad < bs) return 6;
    room = TOP_FULL - {1'b0, ad};
    if ({{(ADDR_W+1-LEN_W){1'b0}}, ln} >= room) return 6;
    lastEnd = {1'b0, ad} + {{(ADDR_W+1-LEN_W){1'b0}}, ln};
    if (lastEnd > tp) return 6;
    return 0;
  endfunction

  task automatic access(input bit tg, input bit sl, input logic [PERM_W-1:0] pm,
      input logic [ADDR_W-1:0] bs, input logic [ADDR_W:0] tp, input logic [PERM_W-1:0] rq,
      input logic [ADDR_W-1:0] ad, input logic [LEN_W-1:0] ln, input logic [REG_W-1:0] rn,
      input string req);
    int c;
    @(negedge clk);
    capTag = tg; capSealed = sl; capPerms = pm; capBase = bs; capTop = tp;
    reqPerms = rq; accAddr = ad; accLen = ln; capRegNum = rn; chkValid = 1'b1;
    c = refCause(tg, sl, pm, bs, tp, rq, ad, ln);
    expCause = 3'(c);
    if (c != 0) begin expBad = ad; expReg = rn; end
    @(negedge clk);
    chkValid = 1'b0;
    check(resValid == 1'b1, req, "resValid", 65'(resValid), 65'd1);
    check(resCause == expCause, req, "resCause", 65'(resCause), 65'(expCause));
    check(resFault == (c != 0), req, "resFault", 65'(resFault), 65'(c != 0));
    check(badAddr == expBad, req, "badAddr", 65'(badAddr), 65'(expBad));
    check(resRegNum == expReg, req, "resRegNum", 65'(resRegNum), 65'(expReg));
    // Idle cycle: pulse gone, result held (R9)
    capTag = ~tg; accAddr = ~ad; capRegNum = ~rn;
    @(negedge clk);
    check(resValid == 1'b0, "R9", "resValid idle", 65'(resValid), 65'd0);
    check(resCause == expCause, "R9", "resCause held", 65'(resCause), 65'(expCause));
    check(badAddr == expBad, "R10", "badAddr held", 65'(badAddr), 65'(expBad));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(resValid == 0, "R11", "resValid", 65'(resValid), 0);
    check(resFault == 0, "R11", "resFault", 65'(resFault), 0);
    check(resCause == 0, "R11", "resCause", 65'(resCause), 0);
    check(badAddr == 0, "R11", "badAddr", 65'(badAddr), 0);
    check(resRegNum == 0, "R11", "resRegNum", 65'(resRegNum), 0);

    // R1: tag clear masks seal, perm and bounds
    access(0, 1, 12'h000, 64'h1000, 65'h2000, MX, 64'h10, 16'h8, 5'd3, "R1");
    // R2: seal masks perm and bounds
    access(1, 1, 12'h000, 64'h1000, 65'h2000, ML, 64'h10, 16'h8, 5'd4, "R2");
    // R3 and R8: permission kinds ahead of bounds
    access(1, 0, 12'hFFD, 64'h1000, 65'h2000, MX, 64'h10, 16'h8, 5'd5, "R3");
    access(1, 0, 12'hFFB, 64'h1000, 65'h2000, ML, 64'h1100, 16'h8, 5'd6, "R3");
    access(1, 0, 12'hFF7, 64'h1000, 65'h2000, MS, 64'h1100, 16'h8, 5'd7, "R3");
    // R10: passing access leaves fault info unchanged
    access(1, 0, 12'hFFF, 64'h1000, 65'h2000, MS, 64'h1100, 16'h8, 5'd8, "R10");
    // R4: multi-bit requests never give a permission cause
    access(1, 0, 12'h000, 64'h1000, 65'h2000, MX | ML, 64'h1100, 16'h8, 5'd9, "R4");
    access(1, 0, 12'h000, 64'h1000, 65'h2000, MX | MS, 64'h1FFF, 16'h8, 5'd10, "R4");
    // R5: base edge
    access(1, 0, 12'hFFF, 64'h1000, 65'h2000, ML, 64'h0FFF, 16'h1, 5'd11, "R5");
    access(1, 0, 12'hFFF, 64'h1000, 65'h2000, ML, 64'h1000, 16'h1, 5'd12, "R5");
    // R7: top edge
    access(1, 0, 12'hFFF, 64'h1000, 65'h2000, ML, 64'h1FF8, 16'h8, 5'd13, "R7");
    access(1, 0, 12'hFFF, 64'h1000, 65'h2000, ML, 64'h1FF9, 16'h8, 5'd14, "R7");
    // R6: carry edge
    access(1, 0, 12'hFFF, 64'h0, TOP_FULL, ML, {ADDR_W{1'b1}}, 16'h1, 5'd15, "R6");
    access(1, 0, 12'hFFF, 64'h0, {(ADDR_W+1){1'b1}}, ML, {ADDR_W{1'b1}}, 16'h1, 5'd16, "R6");
    access(1, 0, 12'hFFF, 64'h0, {(ADDR_W+1){1'b1}}, MS, 64'hFFFF_FFFF_FFFF_FFF0, 16'h20, 5'd17, "R6");
    access(1, 0, 12'hFFF, 64'h0, TOP_FULL, ML, {ADDR_W{1'b1}}, 16'h0, 5'd18, "R6");

    // R8: random descriptors against the priority model
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] bs;
      logic [ADDR_W:0]   tp;
      logic [ADDR_W-1:0] ad;
      logic [PERM_W-1:0] rq;
      int sel;
      bs = {$urandom, $urandom};
      if (($urandom % 4) == 0) bs = {ADDR_W{1'b1}} - 64'($urandom % 256);
      tp = {1'b0, bs} + 65'($urandom % 512);
      if (($urandom % 8) == 0) tp = TOP_FULL;
      ad = bs + 64'($urandom % 600) - 64'd40;
      sel = $urandom % 5;
      rq = (sel == 0) ? MX : (sel == 1) ? ML : (sel == 2) ? MS : (sel == 3) ? (ML | MS) : 12'($urandom);
      access(($urandom % 8) != 0, ($urandom % 8) == 0, 12'($urandom) | 12'hFF0,
             bs, tp, rq, ad, 16'($urandom % 80), 5'($urandom), "R8");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule